// File: doc/BRIEF.md
# CAN Receive Message FIFO

This block buffers frames taken off a CAN bus until software has read them. The receive engine pushes the bytes of each frame one at a time with a write strobe. It then closes the frame with an end-of-frame strobe that carries the frame's 4-bit length code. The bytes go into a circular byte store, and each closed frame gets one entry in a separate frame table. The entry holds the length code, the number of bytes actually kept and an overrun flag.

The reader only ever sees the oldest complete frame. Its bytes are addressed by an offset from the frame's first byte, and its length code and overrun flag appear on dedicated outputs. A release pulse drops that frame as a whole. Frames are never consumed byte by byte. Status outputs give the bytes held, the frames held and an empty flag.

The frame table stores the length code as given, separately from the byte tally. A remote-request frame therefore keeps only the header bytes that were pushed for it, yet still reports the length code it carried. The defaults are a 64-byte store and a 32-entry table. Both depths must be powers of two. A single frame must not push more bytes than the store holds.

Top module: `can_rx_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears itself. Afterwards `empty` is 1, `byte_cnt` and `pkt_cnt` are 0, and `head_len` and `head_ovr` are 0.
- R2: The bytes of the oldest complete frame appear on `rd_data`, combinationally, in the order they were pushed. `rd_off` = 0 selects the first byte.
- R3: An end-of-frame pulse with the table not full adds one frame, so `pkt_cnt` rises by 1 after that edge. Each byte accepted raises `byte_cnt` by 1 after its edge.
- R4: `head_len` reports the 4-bit length code given with the frame, whatever number of bytes the frame stored, including zero.
- R5: A release pulse while `empty` is 0 removes the oldest frame. In the next cycle `pkt_cnt` has fallen by 1, `byte_cnt` has fallen by that frame's kept bytes, and the next frame is at the head.
- R6: A release pulse while `empty` is 1 changes nothing.
- R7: A byte pushed while `byte_cnt` equals the store depth is discarded, and the open frame is marked overrun. That frame is still entered into the table, shows `head_ovr` = 1 with the bytes it did keep, and is released like any other frame.
- R8: A byte accepted in the same cycle as a release changes `byte_cnt` by the net amount (+1 minus the released bytes). An end-of-frame pulse in the same cycle as a release leaves `pkt_cnt` unchanged.
- R9: While the table holds its full count of frames, pushed bytes are discarded and end-of-frame pulses are ignored. Neither count changes.
- R10: Byte addressing wraps modulo the store depth, and the frame count stays correct when the table pointers wrap.
- R11: `empty` is 1 exactly when `pkt_cnt` is 0. While `empty` is 1, `head_len` and `head_ovr` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Push one byte of the open frame |
| wr_data | input | 8 | Byte to push |
| frame_done | input | 1 | Close the open frame |
| frame_len | input | 4 | Length code of the frame being closed |
| rel_req | input | 1 | Drop the oldest complete frame |
| rd_off | input | 6 | Byte offset within the oldest frame |
| rd_data | output | 8 | Byte at `rd_off` of the oldest frame |
| head_len | output | 4 | Length code of the oldest frame |
| head_ovr | output | 1 | Overrun flag of the oldest frame |
| byte_cnt | output | 7 | Bytes held, including those of the open frame |
| pkt_cnt | output | 6 | Complete frames held |
| empty | output | 1 | No complete frame held |

## Verification
On every cycle, the assertions check the counter arithmetic:
- the bounds on both counts;
- that a lone byte write raises the byte count;
- that a frame close or a release moves the frame count by one;
- that a release on an empty FIFO leaves both counts alone;
- that the head outputs stay zero while empty.

The remaining behaviours depend on data and history, so only the bench's scenarios can show them:
- that the bytes come back in order at each offset across several wraps of the store;
- that the kept-byte tally of an overrun frame is right;
- that a frame closed against a full table never appears;
- that a release moves the read point by exactly the right number of bytes.

// File: rtl/can_rxf_pkg.sv
// Shared types for the CAN receive message FIFO.
// Assumes the CAN data length code is four bits wide.
package can_rxf_pkg;
    typedef logic [7:0] byte_t;
    typedef logic [3:0] len_t;
endpackage

// File: rtl/rxf_data_store.sv
// Circular byte store for received frame bytes.
// The write pointer advances once for each kept byte. The read pointer jumps
// by a whole frame's byte tally on release. Reads are combinational,
// relative to the read pointer.
// Assumes DEPTH is a power of two, so pointer sums wrap for free.
module rxf_data_store
    import can_rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW  = $clog2(DEPTH),
    localparam int CW  = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  byte_t         wdata,
    input  logic          adv,
    input  logic [CW-1:0] adv_amt,
    input  logic [AW-1:0] rd_off,
    output byte_t         rdata
);
    byte_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] rd_addr;

    // Store the incoming byte; the array needs no reset.
    always_ff @(posedge clk) begin
        if (we) mem[wr_ptr] <= wdata;
    end

    // Move the write pointer per byte and the read pointer per released frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (we)  wr_ptr <= wr_ptr + AW'(1);
            if (adv) rd_ptr <= rd_ptr + adv_amt[AW-1:0];
        end
    end

    // Offset read within the oldest frame, wrapping modulo DEPTH.
    always_comb begin
        rd_addr = rd_ptr + rd_off;
        rdata   = mem[rd_addr];
    end
endmodule

// File: rtl/rxf_frame_acc.sv
// Tracks the frame being received: bytes kept so far and whether any were dropped.
// The outputs already include a byte that arrives in the closing cycle.
// Both trackers clear when the frame is closed.
module rxf_frame_acc #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_in,
    input  logic          byte_kept,
    input  logic          close,
    output logic [CW-1:0] nbytes,
    output logic          ovr
);
    logic [CW-1:0] cur_n;
    logic          cur_ovr;

    // Tally including the current cycle's byte.
    always_comb begin
        nbytes = cur_n + CW'(byte_kept);
        ovr    = cur_ovr | (byte_in & ~byte_kept);
    end

    // Accumulate until the frame closes, then restart.
    always_ff @(posedge clk) begin
        if (!rst_n || close) begin
            cur_n   <= '0;
            cur_ovr <= 1'b0;
        end else if (byte_in) begin
            cur_n   <= nbytes;
            cur_ovr <= ovr;
        end
    end
endmodule

// File: rtl/rxf_info_table.sv
// Per-frame table holding the length code, kept-byte tally and overrun flag.
// The pointers carry one extra bit, so the difference gives the count across wrap.
// The head fields read zero while the table is empty.
// Assumes DEPTH is a power of two and push is never asserted when full.
module rxf_info_table
    import can_rxf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CW    = 7,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  len_t          push_len,
    input  logic          push_ovr,
    input  logic [CW-1:0] push_nbytes,
    input  logic          pop,
    output len_t          head_len,
    output logic          head_ovr,
    output logic [CW-1:0] head_nbytes,
    output logic [PW-1:0] count,
    output logic          full,
    output logic          empty
);
    len_t          len_m [DEPTH];
    logic          ovr_m [DEPTH];
    logic [CW-1:0] nb_m  [DEPTH];
    logic [PW-1:0] wr_p;
    logic [PW-1:0] rd_p;

    // Record a closed frame's fields.
    always_ff @(posedge clk) begin
        if (push) begin
            len_m[wr_p[AW-1:0]] <= push_len;
            ovr_m[wr_p[AW-1:0]] <= push_ovr;
            nb_m[wr_p[AW-1:0]]  <= push_nbytes;
        end
    end

    // Advance the write and read entry pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_p <= '0;
            rd_p <= '0;
        end else begin
            if (push) wr_p <= wr_p + PW'(1);
            if (pop)  rd_p <= rd_p + PW'(1);
        end
    end

    // Occupancy flags and the gated head entry.
    always_comb begin
        count       = wr_p - rd_p;
        full        = (count == PW'(DEPTH));
        empty       = (count == '0);
        head_len    = empty ? '0   : len_m[rd_p[AW-1:0]];
        head_ovr    = empty ? 1'b0 : ovr_m[rd_p[AW-1:0]];
        head_nbytes = empty ? '0   : nb_m[rd_p[AW-1:0]];
    end
endmodule

// File: rtl/can_rx_fifo.sv
// CAN receive message FIFO: a byte store plus a per-frame table, with whole-frame release.
// A byte is kept only while the store has room and the table is not full.
// An end-of-frame pulse is honoured only while the table has a free entry.
// Assumes no single frame pushes more than DATA_DEPTH bytes.
module can_rx_fifo
    import can_rxf_pkg::*;
#(
    parameter int DATA_DEPTH = 64,
    parameter int INFO_DEPTH = 32,
    localparam int DA_W = $clog2(DATA_DEPTH),
    localparam int CNT_W = DA_W + 1,
    localparam int PC_W = $clog2(INFO_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             frame_done,
    input  logic [3:0]       frame_len,
    input  logic             rel_req,
    input  logic [DA_W-1:0]  rd_off,
    output logic [7:0]       rd_data,
    output logic [3:0]       head_len,
    output logic             head_ovr,
    output logic [CNT_W-1:0] byte_cnt,
    output logic [PC_W-1:0]  pkt_cnt,
    output logic             empty
);
    logic [CNT_W-1:0] byte_cnt_q;
    logic [CNT_W-1:0] head_nbytes;
    logic [CNT_W-1:0] acc_nbytes;
    logic             acc_ovr;
    logic             info_full;
    logic             byte_ok;
    logic             rel_ok;
    logic             rec_ok;

    // Gate the three events on the occupancy state.
    always_comb begin
        byte_ok = wr_en && !info_full && (byte_cnt_q < CNT_W'(DATA_DEPTH));
        rel_ok  = rel_req && !empty;
        rec_ok  = frame_done && !info_full;
    end

    // Byte occupancy, net of a same-cycle write and release.
    always_ff @(posedge clk) begin
        if (!rst_n) byte_cnt_q <= '0;
        else        byte_cnt_q <= byte_cnt_q + CNT_W'(byte_ok) - (rel_ok ? head_nbytes : '0);
    end

    assign byte_cnt = byte_cnt_q;

    rxf_data_store #(.DEPTH(DATA_DEPTH)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (byte_ok),
        .wdata   (wr_data),
        .adv     (rel_ok),
        .adv_amt (head_nbytes),
        .rd_off  (rd_off),
        .rdata   (rd_data)
    );

    rxf_frame_acc #(.CW(CNT_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_in   (wr_en),
        .byte_kept (byte_ok),
        .close     (frame_done),
        .nbytes    (acc_nbytes),
        .ovr       (acc_ovr)
    );

    rxf_info_table #(.DEPTH(INFO_DEPTH), .CW(CNT_W)) u_info (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (rec_ok),
        .push_len    (frame_len),
        .push_ovr    (acc_ovr),
        .push_nbytes (acc_nbytes),
        .pop         (rel_ok),
        .head_len    (head_len),
        .head_ovr    (head_ovr),
        .head_nbytes (head_nbytes),
        .count       (pkt_cnt),
        .full        (info_full),
        .empty       (empty)
    );
endmodule

// File: rtl/can_rx_fifo_checker.sv
// Property checker for can_rx_fifo, attached by bind. It observes ports only.
module can_rx_fifo_checker #(
    parameter int DATA_DEPTH = 64,
    parameter int INFO_DEPTH = 32,
    localparam int CNT_W = $clog2(DATA_DEPTH) + 1,
    localparam int PC_W  = $clog2(INFO_DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             frame_done,
    input logic             rel_req,
    input logic [3:0]       head_len,
    input logic             head_ovr,
    input logic [CNT_W-1:0] byte_cnt,
    input logic [PC_W-1:0]  pkt_cnt,
    input logic             empty
);
    // R7
    byte_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= CNT_W'(DATA_DEPTH));

    // R9
    pkt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_cnt <= PC_W'(INFO_DEPTH));

    // R9
    full_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cnt == PC_W'(INFO_DEPTH) && frame_done && !rel_req) |=> $stable(pkt_cnt));

    // R3
    close_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && pkt_cnt < PC_W'(INFO_DEPTH) && !rel_req) |=> pkt_cnt == $past(pkt_cnt) + PC_W'(1));

    // R3
    byte_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rel_req && byte_cnt < CNT_W'(DATA_DEPTH) && pkt_cnt < PC_W'(INFO_DEPTH))
        |=> byte_cnt == $past(byte_cnt) + CNT_W'(1));

    // R5
    release_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && !empty && !frame_done) |=> pkt_cnt == $past(pkt_cnt) - PC_W'(1));

    // R6
    empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && empty && !wr_en && !frame_done) |=> ($stable(byte_cnt) && $stable(pkt_cnt)));

    // R11
    empty_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (head_len == 4'd0 && !head_ovr));
endmodule

bind can_rx_fifo can_rx_fifo_checker #(.DATA_DEPTH(DATA_DEPTH), .INFO_DEPTH(INFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .frame_done (frame_done),
    .rel_req    (rel_req),
    .head_len   (head_len),
    .head_ovr   (head_ovr),
    .byte_cnt   (byte_cnt),
    .pkt_cnt    (pkt_cnt),
    .empty      (empty)
);

// File: tb/can_rx_fifo_test.sv
`timescale 1ns/1ps
// Bench for can_rx_fifo: sweeps frame sizes through several store wraps, then
// drives the overrun, full-table and same-cycle corners. Expected values are
// computed arithmetically.
module can_rx_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       frame_done = 1'b0;
    logic [3:0] frame_len = 4'd0;
    logic       rel_req = 1'b0;
    logic [5:0] rd_off = 6'd0;
    logic [7:0] rd_data;
    logic [3:0] head_len;
    logic       head_ovr;
    logic [6:0] byte_cnt;
    logic [5:0] pkt_cnt;
    logic       empty;

    int errs = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    can_rx_fifo uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .frame_done(frame_done), .frame_len(frame_len), .rel_req(rel_req),
        .rd_off(rd_off), .rd_data(rd_data), .head_len(head_len),
        .head_ovr(head_ovr), .byte_cnt(byte_cnt), .pkt_cnt(pkt_cnt), .empty(empty)
    );

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic put_frame(input int nb, input int len, input int seed);
        for (int i = 0; i < nb; i++) begin
            wr_en = 1'b1;
            wr_data = 8'(seed + i);
            tick();
        end
        wr_en = 1'b0;
        frame_done = 1'b1;
        frame_len = 4'(len);
        tick();
        frame_done = 1'b0;
    endtask

    task automatic release_one;
        rel_req = 1'b1;
        tick();
        rel_req = 1'b0;
    endtask

    task automatic check_head(input int nb, input int len, input int ovr, input int seed, input string req);
        chk(int'(head_len), len, req);
        chk(int'(head_ovr), ovr, req);
        for (int off = 0; off < nb; off++) begin
            rd_off = 6'(off);
            #1;
            chk(int'(rd_data), (seed + off) % 256, req);
        end
        tick();
    endtask

    task automatic check_counts(input int b, input int p, input string req);
        chk(int'(byte_cnt), b, req);
        chk(int'(pkt_cnt), p, req);
        chk(int'(empty), (p == 0) ? 1 : 0, req);
    endtask

    function automatic int nb_of(input int k);
        return k % 14;
    endfunction
    function automatic int len_of(input int k);
        return (k * 5 + 3) % 16;
    endfunction
    function automatic int seed_of(input int k);
        return (k * 37) % 256;
    endfunction

    initial begin
        repeat (3) tick();
        // R1 reset state
        check_counts(0, 0, "R1");
        chk(int'(head_len), 0, "R1");
        chk(int'(head_ovr), 0, "R1");
        rst_n = 1'b1;
        tick();

        // R6 release on empty, R11 head fields zero when empty
        release_one();
        check_counts(0, 0, "R6");
        chk(int'(head_len), 0, "R11");
        chk(int'(head_ovr), 0, "R11");

        // R2 R3 R4 R5 R10 sweep of frame sizes through several wraps
        for (int k = 0; k < 40; k++) begin
            put_frame(nb_of(k), len_of(k), seed_of(k));
            if (k == 0) check_counts(nb_of(0), 1, "R3");
            else        check_counts(nb_of(k - 1) + nb_of(k), 2, "R3");
            if (k >= 1) begin
                check_head(nb_of(k - 1), len_of(k - 1), 0, seed_of(k - 1), "R2");
                release_one();
                check_counts(nb_of(k), 1, "R5");
                chk(int'(head_len), len_of(k), "R10");
            end
        end
        check_head(nb_of(39), len_of(39), 0, seed_of(39), "R4");
        release_one();
        check_counts(0, 0, "R5");

        // R7 overrun: 60 bytes held, then a 10-byte frame keeps only 4
        for (int f = 0; f < 5; f++) put_frame(12, 8, 100 + f * 16);
        put_frame(10, 8, 200);
        check_counts(64, 6, "R7");
        for (int f = 0; f < 5; f++) begin
            check_head(12, 8, 0, 100 + f * 16, "R7");
            release_one();
        end
        check_counts(4, 1, "R7");
        check_head(4, 8, 1, 200, "R7");
        release_one();
        check_counts(0, 0, "R7");

        // R9 full frame table drops further bytes and closes
        for (int f = 0; f < 32; f++) put_frame(1, f % 16, f + 1);
        check_counts(32, 32, "R9");
        put_frame(2, 5, 250);
        check_counts(32, 32, "R9");
        check_head(1, 0, 0, 1, "R9");
        release_one();
        check_counts(31, 31, "R9");
        for (int f = 1; f < 32; f++) begin
            check_head(1, f % 16, 0, f + 1, "R9");
            release_one();
        end
        check_counts(0, 0, "R9");

        // R8 same-cycle write or close with release
        put_frame(5, 5, 10);
        put_frame(3, 3, 20);
        check_counts(8, 2, "R8");
        wr_en = 1'b1;
        wr_data = 8'd30;
        rel_req = 1'b1;
        tick();
        wr_en = 1'b0;
        rel_req = 1'b0;
        check_counts(4, 1, "R8");
        frame_done = 1'b1;
        frame_len = 4'd1;
        rel_req = 1'b1;
        tick();
        frame_done = 1'b0;
        rel_req = 1'b0;
        check_counts(1, 1, "R8");
        check_head(1, 1, 0, 30, "R8");
        release_one();
        check_counts(0, 0, "R11");
        chk(int'(head_ovr), 0, "R11");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule